// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block turns a byte-range program or erase request into the sequence of serial-flash commands that a flash device needs. A request gives the kind of operation, the start address and the byte count. The block breaks a program request into pieces that never cross a 256-byte page. It breaks an erase request into 4096-byte sectors. Before each piece it sends the write-enable command. It then reads the status register until the write-enable latch bit is set. Next it sends the program or erase command and reads status until the busy bit clears. Each command goes out through a separate command transfer engine. The block raises a start strobe with the opcode, the address and the write length, and waits for the engine's completion strobe. For a status read, the byte the engine returns comes with that strobe.

Program data is never stored in the block. When the engine pulls a byte during a program command, the block passes the pull back to the caller's byte stream, and the caller's byte goes straight through to the engine. The block counts the status reads in each polling loop. Between two reads it waits a set number of cycles, and after each program command it waits before the first status read. If a polling loop runs out of reads, the request ends with an error. An erase request whose address or length is not sector aligned is refused before any command goes out.

The controller is a single state machine. Its states are: IDLE (waiting for a request), CHECK (alignment and empty-request test), WREN_SEND and WREN_WAIT (write-enable command), WEL_RD, WEL_WAIT and WEL_GAP (latch polling), OP_SEND and OP_WAIT (program or erase command), PROG_HOLD (settling wait after a program command), WIP_RD, WIP_WAIT and WIP_GAP (busy polling), NEXT (advance to the next piece), DONE_OK and DONE_ERR (one-cycle completion). The transitions are:
- IDLE to CHECK on a request.
- CHECK to DONE_ERR if misaligned, to DONE_OK if the length is zero, otherwise to WREN_SEND.
- Each SEND or RD state moves to its WAIT state after one cycle.
- A WAIT state moves on when the engine reports completion.
- WEL_WAIT goes to OP_SEND when the latch is set. Otherwise it goes to WEL_GAP, or to DONE_ERR when the reads are used up.
- WEL_GAP goes back to WEL_RD when its timer expires.
- OP_WAIT goes to PROG_HOLD for a program, or straight to WIP_RD for an erase.
- PROG_HOLD goes to WIP_RD when its timer expires.
- WIP_WAIT goes to NEXT when the busy bit is clear. Otherwise it goes to WIP_GAP, or to DONE_ERR when the reads are used up.
- WIP_GAP goes back to WIP_RD when its timer expires.
- NEXT goes to DONE_OK after the last piece, otherwise back to WREN_SEND.
- Both DONE states return to IDLE.

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset, and whenever reset is asserted during a request, `busy`, `done`, `error` and `eng_start` are low.
- R2: Every program piece and every erase sector begins with opcode 0x06 without an address. This is followed by status reads (opcode 0x05, `eng_read` high, no address), repeated until bit 1 of the returned byte is 1.
- R3: A program piece uses opcode 0x02 with `eng_has_addr` high and the current address. Its write length is the smaller of two values: the remaining count, and 256 minus (address mod 256). The address then advances, and the remaining count drops, by that length until it reaches zero.
- R4: An erase sector uses opcode 0x20 with `eng_has_addr` high, the current address and a write length of 0. The address advances by 4096 per sector.
- R5: After each program or erase command, status (0x05) is read until bit 0 of the returned byte is 0. After a program command, the first such read starts at least `PROG_WAIT_CYC` cycles after the command's start. After an erase command, the first read starts with no added wait.
- R6: After a status read that does not meet its condition, the next status read starts at least `POLL_GAP_CYC` cycles after the failed one started.
- R7: If `POLL_LIMIT` consecutive status reads in one polling loop all fail, the request ends with `done` and `error` high together, and no further command is sent.
- R8: An erase request whose address or length has any of bits 11..0 set ends with `done` and `error` and sends no command.
- R9: A request of length zero ends with `done` and no `error` and sends no command.
- R10: `done` is high for exactly one cycle per request. A request offered while `busy` is high is ignored.
- R11: `pdata_take` follows `eng_wpull` only while a program command is in progress, so the caller supplies exactly as many bytes as the request's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_erase | input | 1 | 1 = sector erase, 0 = program |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| pdata | input | 8 | Caller's program byte stream |
| pdata_take | output | 1 | Caller must advance its byte stream |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure, valid with done |
| eng_start | output | 1 | One-cycle command start to the engine |
| eng_op | output | 8 | Command opcode |
| eng_has_addr | output | 1 | Command carries a three-byte address |
| eng_addr | output | ADDR_W | Command address |
| eng_wlen | output | PG_W | Data bytes to write after the address |
| eng_read | output | 1 | Command reads one status byte back |
| eng_wpull | input | 1 | Engine takes one program byte |
| eng_wdata | output | 8 | Program byte to the engine |
| eng_done | input | 1 | Engine finished the current command |
| eng_rdata | input | 8 | Status byte, valid with eng_done |

## Verification
The bench aims at programs that start just below a page boundary, span one or more full pages, or end exactly on a boundary. A design that splits pieces wrongly would send a piece that wraps inside the page, or an extra piece of length zero. Polling loops are stretched to just under the limit and pushed past it. This exposes a retry counter that is off by one, that is not cleared between loops, or that sends the erase or program command anyway. Misaligned erases, empty requests and a request offered while busy must produce no stray command. Start-to-start spacing of the logged commands shows a missing settle wait or a missing gap between polls.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // Serial-flash opcodes driven onto eng_op
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'h20;

    // Status byte fields
    localparam logic [7:0] ST_WEL_MASK = 8'h02;
    localparam logic [7:0] ST_WIP_MASK = 8'h01;

    typedef enum logic [4:0] {
        S_IDLE,
        S_CHECK,
        S_WREN_SEND,
        S_WREN_WAIT,
        S_WEL_RD,
        S_WEL_WAIT,
        S_WEL_GAP,
        S_OP_SEND,
        S_OP_WAIT,
        S_PROG_HOLD,
        S_WIP_RD,
        S_WIP_WAIT,
        S_WIP_GAP,
        S_NEXT,
        S_DONE_OK,
        S_DONE_ERR
    } seq_state_e;

endpackage

// File: rtl/fps_cursor.sv
module fps_cursor #(
    parameter int ADDR_W       = 24,
    parameter int LEN_W        = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    localparam int PG_LOG      = $clog2(PAGE_BYTES),
    localparam int SEC_LOG     = $clog2(SECTOR_BYTES),
    localparam int PG_W        = PG_LOG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              in_erase,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    output logic              is_erase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [PG_W-1:0]   prog_len,
    output logic              rem_zero,
    output logic              last,
    output logic              misaligned
);

    logic              erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  room;
    logic [LEN_W-1:0]  chunk;

    // Piece size: a whole sector, or what is left of the current page
    always_comb begin
        room = LEN_W'(PAGE_BYTES) - LEN_W'(addr_q[PG_LOG-1:0]);
        if (erase_q) begin
            chunk = LEN_W'(SECTOR_BYTES);
        end else begin
            chunk = (rem_q < room) ? rem_q : room;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_q <= 1'b0;
            addr_q  <= '0;
            rem_q   <= '0;
        end else if (load) begin
            erase_q <= in_erase;
            addr_q  <= in_addr;
            rem_q   <= in_len;
        end else if (step) begin
            addr_q  <= addr_q + ADDR_W'(chunk);
            rem_q   <= rem_q - chunk;
        end
    end

    assign is_erase   = erase_q;
    assign cur_addr   = addr_q;
    assign prog_len   = chunk[PG_W-1:0];
    assign rem_zero   = (rem_q == '0);
    assign last       = (rem_q <= chunk);
    assign misaligned = erase_q && ((|addr_q[SEC_LOG-1:0]) || (|rem_q[SEC_LOG-1:0]));

    // R3
    page_align_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !erase_q) |=> ((addr_q[PG_LOG-1:0] == '0) || (rem_q == '0)));

    // R4
    sector_align_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && erase_q) |=> (addr_q[SEC_LOG-1:0] == '0));

endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
    parameter int GAP_CYC    = 100000,
    parameter int HOLD_CYC   = 100000,
    parameter int POLL_LIMIT = 10000,
    localparam int WAIT_MAX  = (GAP_CYC > HOLD_CYC) ? GAP_CYC : HOLD_CYC,
    localparam int CW        = $clog2(WAIT_MAX + 1),
    localparam int TW        = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_load,
    input  logic hold_load,
    input  logic tries_clr,
    input  logic tries_inc,
    output logic wait_over,
    output logic tries_last
);

    logic [CW-1:0] cnt_q;
    logic [TW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (gap_load) begin
            cnt_q <= CW'(GAP_CYC);
        end else if (hold_load) begin
            cnt_q <= CW'(HOLD_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (tries_clr) begin
            tries_q <= '0;
        end else if (tries_inc) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign wait_over  = (cnt_q == '0);
    assign tries_last = (tries_q == TW'(POLL_LIMIT - 1));

    // R7
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TW'(POLL_LIMIT));

    // R6
    wait_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_load || hold_load) |=> !wait_over);

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import fps_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int LEN_W         = 24,
    parameter int PAGE_BYTES    = 256,
    parameter int SECTOR_BYTES  = 4096,
    parameter int POLL_LIMIT    = 10000,
    parameter int POLL_GAP_CYC  = 100000,
    parameter int PROG_WAIT_CYC = 100000,
    localparam int PG_LOG       = $clog2(PAGE_BYTES),
    localparam int SEC_LOG      = $clog2(SECTOR_BYTES),
    localparam int PG_W         = PG_LOG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        pdata,
    output logic              pdata_take,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              eng_start,
    output logic [7:0]        eng_op,
    output logic              eng_has_addr,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [PG_W-1:0]   eng_wlen,
    output logic              eng_read,
    input  logic              eng_wpull,
    output logic [7:0]        eng_wdata,
    input  logic              eng_done,
    input  logic [7:0]        eng_rdata
);

    seq_state_e state_q, state_d;

    logic              ld_cur, step_cur;
    logic              gap_ld, hold_ld, tr_clr, tr_inc;
    logic              is_erase, rem_zero, last, misaligned;
    logic              wait_over, tries_last;
    logic [ADDR_W-1:0] cur_addr;
    logic [PG_W-1:0]   prog_len;
    logic              wel_set, wip_set;

    fps_cursor #(
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld_cur),
        .step       (step_cur),
        .in_erase   (req_erase),
        .in_addr    (req_addr),
        .in_len     (req_len),
        .is_erase   (is_erase),
        .cur_addr   (cur_addr),
        .prog_len   (prog_len),
        .rem_zero   (rem_zero),
        .last       (last),
        .misaligned (misaligned)
    );

    fps_poll_timer #(
        .GAP_CYC    (POLL_GAP_CYC),
        .HOLD_CYC   (PROG_WAIT_CYC),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gap_load   (gap_ld),
        .hold_load  (hold_ld),
        .tries_clr  (tr_clr),
        .tries_inc  (tr_inc),
        .wait_over  (wait_over),
        .tries_last (tries_last)
    );

    assign wel_set = (eng_rdata & ST_WEL_MASK) != 8'h00;
    assign wip_set = (eng_rdata & ST_WIP_MASK) != 8'h00;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and the strobes tied to them
    always_comb begin
        state_d  = state_q;
        ld_cur   = 1'b0;
        step_cur = 1'b0;
        gap_ld   = 1'b0;
        hold_ld  = 1'b0;
        tr_clr   = 1'b0;
        tr_inc   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    ld_cur  = 1'b1;
                    state_d = S_CHECK;
                end
            end
            S_CHECK: begin
                if (misaligned)    state_d = S_DONE_ERR;
                else if (rem_zero) state_d = S_DONE_OK;
                else               state_d = S_WREN_SEND;
            end
            S_WREN_SEND: begin
                tr_clr  = 1'b1;
                state_d = S_WREN_WAIT;
            end
            S_WREN_WAIT: begin
                if (eng_done) state_d = S_WEL_RD;
            end
            S_WEL_RD: state_d = S_WEL_WAIT;
            S_WEL_WAIT: begin
                if (eng_done) begin
                    if (wel_set) begin
                        state_d = S_OP_SEND;
                    end else if (tries_last) begin
                        state_d = S_DONE_ERR;
                    end else begin
                        tr_inc  = 1'b1;
                        gap_ld  = 1'b1;
                        state_d = S_WEL_GAP;
                    end
                end
            end
            S_WEL_GAP: begin
                if (wait_over) state_d = S_WEL_RD;
            end
            S_OP_SEND: begin
                tr_clr  = 1'b1;
                state_d = S_OP_WAIT;
            end
            S_OP_WAIT: begin
                if (eng_done) begin
                    if (is_erase) begin
                        state_d = S_WIP_RD;
                    end else begin
                        hold_ld = 1'b1;
                        state_d = S_PROG_HOLD;
                    end
                end
            end
            S_PROG_HOLD: begin
                if (wait_over) state_d = S_WIP_RD;
            end
            S_WIP_RD: state_d = S_WIP_WAIT;
            S_WIP_WAIT: begin
                if (eng_done) begin
                    if (!wip_set) begin
                        state_d = S_NEXT;
                    end else if (tries_last) begin
                        state_d = S_DONE_ERR;
                    end else begin
                        tr_inc  = 1'b1;
                        gap_ld  = 1'b1;
                        state_d = S_WIP_GAP;
                    end
                end
            end
            S_WIP_GAP: begin
                if (wait_over) state_d = S_WIP_RD;
            end
            S_NEXT: begin
                step_cur = 1'b1;
                state_d  = last ? S_DONE_OK : S_WREN_SEND;
            end
            S_DONE_OK:  state_d = S_IDLE;
            S_DONE_ERR: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state alone
    always_comb begin
        eng_start    = 1'b0;
        eng_op       = 8'h00;
        eng_has_addr = 1'b0;
        eng_addr     = '0;
        eng_wlen     = '0;
        eng_read     = 1'b0;
        busy         = 1'b1;
        done         = 1'b0;
        error        = 1'b0;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_WREN_SEND, S_WREN_WAIT: begin
                eng_start = (state_q == S_WREN_SEND);
                eng_op    = OP_WREN;
            end
            S_WEL_RD, S_WEL_WAIT, S_WIP_RD, S_WIP_WAIT: begin
                eng_start = (state_q == S_WEL_RD) || (state_q == S_WIP_RD);
                eng_op    = OP_RDSR;
                eng_read  = 1'b1;
            end
            S_OP_SEND, S_OP_WAIT: begin
                eng_start    = (state_q == S_OP_SEND);
                eng_op       = is_erase ? OP_SERASE : OP_PROG;
                eng_has_addr = 1'b1;
                eng_addr     = cur_addr;
                eng_wlen     = is_erase ? '0 : prog_len;
            end
            S_DONE_OK: begin
                busy = 1'b0;
                done = 1'b1;
            end
            S_DONE_ERR: begin
                busy  = 1'b0;
                done  = 1'b1;
                error = 1'b1;
            end
            default: ;
        endcase
    end

    assign pdata_take = eng_wpull && (state_q == S_OP_WAIT) && !is_erase;
    assign eng_wdata  = pdata;

    // R3
    page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == OP_PROG) |->
            (eng_wlen != '0) && ((int'(eng_addr[PG_LOG-1:0]) + int'(eng_wlen)) <= PAGE_BYTES));

    // R4
    sector_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == OP_SERASE) |-> (eng_addr[SEC_LOG-1:0] == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

endmodule

// File: tb/tb_flash_pe_sequencer.sv
`timescale 1ns/1ps
module tb_flash_pe_sequencer;

    localparam int LIMIT = 6;
    localparam int GAP   = 8;
    localparam int HOLD  = 20;
    localparam int NV    = 12;

    typedef struct packed {
        logic        er;
        logic [23:0] addr;
        logic [23:0] len;
        logic [7:0]  wel;
        logic [7:0]  wip;
        logic        xerr;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 24'h000010, 24'd4,      8'd0,   8'd0,   1'b0},
        '{1'b0, 24'h0000F0, 24'h30,     8'd0,   8'd1,   1'b0},
        '{1'b0, 24'h0001FF, 24'd258,    8'd1,   8'd0,   1'b0},
        '{1'b0, 24'h000400, 24'd256,    8'd2,   8'd3,   1'b0},
        '{1'b1, 24'h002000, 24'h2000,   8'd1,   8'd2,   1'b0},
        '{1'b1, 24'h003000, 24'h1000,   8'd0,   8'd5,   1'b0},
        '{1'b1, 24'h003100, 24'h1000,   8'd0,   8'd0,   1'b1},
        '{1'b1, 24'h004000, 24'h1800,   8'd0,   8'd0,   1'b1},
        '{1'b0, 24'h000123, 24'd0,      8'd0,   8'd0,   1'b0},
        '{1'b0, 24'h000080, 24'd16,     8'd100, 8'd0,   1'b1},
        '{1'b1, 24'h005000, 24'h1000,   8'd0,   8'd100, 1'b1},
        '{1'b1, 24'h006000, 24'd0,      8'd0,   8'd0,   1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [23:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic [7:0]  pdata = '0;
    logic        pdata_take, busy, done, error;
    logic        eng_start, eng_has_addr, eng_read;
    logic [7:0]  eng_op, eng_wdata;
    logic [23:0] eng_addr;
    logic [8:0]  eng_wlen;
    logic        eng_wpull = 1'b0;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rdata = '0;

    flash_pe_sequencer #(
        .POLL_LIMIT    (LIMIT),
        .POLL_GAP_CYC  (GAP),
        .PROG_WAIT_CYC (HOLD)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_erase    (req_erase),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .pdata        (pdata),
        .pdata_take   (pdata_take),
        .busy         (busy),
        .done         (done),
        .error        (error),
        .eng_start    (eng_start),
        .eng_op       (eng_op),
        .eng_has_addr (eng_has_addr),
        .eng_addr     (eng_addr),
        .eng_wlen     (eng_wlen),
        .eng_read     (eng_read),
        .eng_wpull    (eng_wpull),
        .eng_wdata    (eng_wdata),
        .eng_done     (eng_done),
        .eng_rdata    (eng_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Command log from the engine model, expected list from the requirements
    logic [42:0] log_key [64];
    int          log_cyc [64];
    int          n_log = 0;
    logic [42:0] exp_key [64];
    int          n_exp = 0;
    int          exp_bytes = 0;

    int cfg_wel = 0, cfg_wip = 0;
    int wel_left = 0, wip_left = 0;
    int m_pull = 0, m_wait = 0;
    logic m_act = 1'b0;
    logic [7:0] m_op = '0;
    int taken = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pdata_take) taken <= taken + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Command transfer engine and flash status model
    always @(negedge clk) begin
        eng_done  = 1'b0;
        eng_wpull = 1'b0;
        if (!rst_n) begin
            m_act = 1'b0;
        end else if (eng_start) begin
            if (n_log < 64) begin
                log_key[n_log] = {eng_op, eng_has_addr, eng_read, eng_addr, eng_wlen};
                log_cyc[n_log] = cyc;
                n_log++;
            end
            m_act  = 1'b1;
            m_op   = eng_op;
            m_pull = (eng_op == 8'h02) ? int'(eng_wlen) : 0;
            m_wait = 2;
        end else if (m_act) begin
            if (m_pull > 0) begin
                eng_wpull = 1'b1;
                pdata     = pdata + 8'd1;
                m_pull--;
            end else if (m_wait > 0) begin
                m_wait--;
            end else begin
                eng_done = 1'b1;
                m_act    = 1'b0;
                case (m_op)
                    8'h06: wel_left = cfg_wel;
                    8'h02, 8'h20: wip_left = cfg_wip;
                    8'h05: begin
                        eng_rdata = {6'b0, wel_left == 0, wip_left != 0};
                        if (wel_left > 0) wel_left--;
                        if (wip_left > 0) wip_left--;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic push(input logic [7:0] op, input logic has, input logic rd,
                        input int a, input int l);
        if (n_exp < 64) begin
            exp_key[n_exp] = {op, has, rd, 24'(a), 9'(l)};
            n_exp++;
        end
    endtask

    task automatic build_exp(input logic er, input int addr, input int len,
                             input int wel, input int wip);
        int a, r, c;
        bit stop;
        n_exp = 0;
        exp_bytes = 0;
        stop = 0;
        a = addr;
        r = len;
        if (er && ((addr % 4096) != 0 || (len % 4096) != 0)) r = 0;
        while (r != 0 && !stop) begin
            c = er ? 4096 : ((r < 256 - (a % 256)) ? r : 256 - (a % 256));
            push(8'h06, 1'b0, 1'b0, 0, 0);
            if (wel >= LIMIT) begin
                for (int k = 0; k < LIMIT; k++) push(8'h05, 1'b0, 1'b1, 0, 0);
                stop = 1;
            end else begin
                for (int k = 0; k <= wel; k++) push(8'h05, 1'b0, 1'b1, 0, 0);
                push(er ? 8'h20 : 8'h02, 1'b1, 1'b0, a, er ? 0 : c);
                if (!er) exp_bytes += c;
                if (wip >= LIMIT) begin
                    for (int k = 0; k < LIMIT; k++) push(8'h05, 1'b0, 1'b1, 0, 0);
                    stop = 1;
                end else begin
                    for (int k = 0; k <= wip; k++) push(8'h05, 1'b0, 1'b1, 0, 0);
                end
            end
            a += c;
            r -= c;
        end
    endtask

    task automatic run_req(input logic er, input int addr, input int len,
                           input int wel, input int wip, input logic xerr, input int poke);
        bit got_done, got_err, seq_ok, gap_ok, hold_ok;
        int k;
        build_exp(er, addr, len, wel, wip);
        cfg_wel = wel;
        cfg_wip = wip;
        @(negedge clk);
        n_log = 0;
        taken = 0;
        done_cnt = 0;
        req_valid = 1'b1;
        req_erase = er;
        req_addr  = 24'(addr);
        req_len   = 24'(len);
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 0;
        got_err  = 0;
        k = 0;
        while (!got_done && k < 20000) begin
            if (poke != 0 && k == poke) begin
                chk(busy == 1'b1, "R10", "busy during request", busy, 1);
                req_valid = 1'b1;
                req_erase = ~er;
                req_addr  = 24'h00A000;
                req_len   = 24'h1000;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin
                got_done = 1;
                got_err  = error;
            end
            @(negedge clk);
            k++;
        end
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
        // R7 R8 R9: error flag with done
        chk(got_err == xerr, "R7/R8/R9", "error with done", got_err, xerr);
        // R2 R3 R4 R5 R7 R8 R9: exact command sequence
        seq_ok = (n_log == n_exp);
        for (int i = 0; i < n_log && i < n_exp; i++)
            if (log_key[i] != exp_key[i]) seq_ok = 0;
        chk(seq_ok, "R2/R3/R4/R5", "command sequence length", n_log, n_exp);
        // R11: bytes handed to the caller
        chk(taken == exp_bytes, "R11", "program bytes taken", taken, exp_bytes);
        gap_ok  = 1;
        hold_ok = 1;
        for (int i = 1; i < n_log; i++) begin
            if (log_key[i-1][42:35] == 8'h05 && log_key[i][42:35] == 8'h05 &&
                log_cyc[i] - log_cyc[i-1] < GAP) gap_ok = 0;
            if (log_key[i-1][42:35] == 8'h02 && log_key[i][42:35] == 8'h05 &&
                log_cyc[i] - log_cyc[i-1] < HOLD) hold_ok = 0;
            if (log_key[i-1][42:35] == 8'h20 && log_key[i][42:35] == 8'h05 &&
                log_cyc[i] - log_cyc[i-1] >= HOLD) hold_ok = 0;
        end
        chk(gap_ok, "R6", "poll spacing", gap_ok, 1);
        chk(hold_ok, "R5", "wait after program or erase", hold_ok, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, done, error, eng_start} == 4'b0, "R1", "outputs in reset",
            {busy, done, error, eng_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, error, eng_start} == 4'b0, "R1", "outputs after reset",
            {busy, done, error, eng_start}, 0);

        for (int i = 0; i < NV; i++)
            run_req(VEC[i].er, int'(VEC[i].addr), int'(VEC[i].len),
                    int'(VEC[i].wel), int'(VEC[i].wip), VEC[i].xerr, 0);

        // R10: request while busy is ignored
        run_req(1'b0, 24'h000F80, 200, 1, 1, 1'b0, 3);

        // R1: reset in the middle of a request
        cfg_wel = 0;
        cfg_wip = 50;
        @(negedge clk);
        req_valid = 1'b1;
        req_erase = 1'b1;
        req_addr  = 24'h007000;
        req_len   = 24'h1000;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, error, eng_start} == 4'b0, "R1", "outputs on mid-request reset",
            {busy, done, error, eng_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_req(1'b0, 24'h000020, 8, 0, 0, 1'b0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule